// File: doc/BRIEF.md
# Pipelined 4x4 Block SAD Engine

This block scores how closely two 4x4 pixel blocks match. Every pixel is an unsigned 8-bit sample. Each of the four rows arrives as one 32-bit word that holds four samples. The engine takes the absolute difference in every lane and adds the four lane differences of each row into a row score. It then sums the four row scores through a fixed two-level adder tree and produces a 12-bit block total.

A block search unit feeds it one candidate per clock. Each candidate carries a tag, which the engine returns beside the total so that each result can be matched to its candidate position. The engine has three register stages: lane differences, row sums, and the tree sum. A single advance signal moves all three stages together. When the consumer holds back `out_ready`, the whole pipe freezes, and no block is lost or repeated. A free-running counter reports how many results have been delivered, so the achieved throughput can be measured.

Top module: `sad4x4_engine`

## Requirements
- R1: Each lane contributes |cur - ref| of its two unsigned 8-bit samples. Lane i of a row occupies bits [8i+7:8i] of the row word, and row r occupies bits [32r+31:32r] of the 128-bit block bus.
- R2: A row score is the sum of its four lane differences. It never exceeds 1020.
- R3: The block total is (row0 + row1) + (row2 + row3). It ranges from 0 (identical blocks) to 4080 (all-zero against all-255) and is presented on 12 bits.
- R4: With `out_ready` held high, a block accepted at a clock edge appears on `out_valid`/`out_sad` after the third clock edge counting that one. Blocks accepted on consecutive edges come out on consecutive cycles.
- R5: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. One block is taken on every edge where `in_valid` and `in_ready` are both high.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sad` and `out_tag` hold their values on the next cycle.
- R7: `out_tag` carries the `in_tag` that was presented with the same block. Results leave in acceptance order.
- R8: Synchronous active-high `rst` empties the pipe, including any blocks in flight. After it, `out_valid` is 0, `out_cnt` is 0 and `in_ready` is 1.
- R9: `out_cnt` rises by exactly one on each edge where `out_valid` and `out_ready` are both high, wraps modulo 2^CNT_W, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Block on the input bus is valid |
| in_ready | output | 1 | Engine takes the block this edge |
| in_cur | input | 128 | Current block, four packed row words |
| in_ref | input | 128 | Reference block, four packed row words |
| in_tag | input | TAG_W | Candidate tag for this block |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_sad | output | 12 | Block sum of absolute differences |
| out_tag | output | TAG_W | Tag of the block that produced out_sad |
| out_cnt | output | CNT_W | Count of delivered results |

## Verification
The assertions check four things on every cycle: the range bound on each row score and on the tree total, that a frozen output holds its value under backpressure, that a valid block is never dropped between stages while the pipe advances, and the step of the delivery counter. The arithmetic itself, the lane and row placement, tag pairing, result order, the exact three-edge latency, and the flush by a reset in mid-stream can only be shown by the bench's scenarios. Those scenarios compare each delivered total with an independent pixel-by-pixel sum over corner blocks, a 4096-pair sweep, and random blocks under random valid and ready patterns.

// File: rtl/sad_pkg.sv
package sad_pkg;

  localparam int PIX_W   = 8;
  localparam int LANES   = 4;
  localparam int ROWS    = 4;
  localparam int WORD_W  = PIX_W * LANES;
  localparam int BLK_W   = WORD_W * ROWS;
  localparam int NPIX    = LANES * ROWS;
  localparam int ROW_W   = PIX_W + $clog2(LANES);
  localparam int PAIR_W  = ROW_W + 1;
  localparam int TOT_W   = PAIR_W + 1;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int ROW_MAX = LANES * PIX_MAX;
  localparam int TOT_MAX = ROWS * ROW_MAX;

  function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                input logic [PIX_W-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  function automatic logic [ROW_W-1:0] lane_total(input logic [WORD_W-1:0] d);
    logic [ROW_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < LANES; i++) acc = acc + ROW_W'(d[i*PIX_W +: PIX_W]);
    return acc;
  endfunction

endpackage

// File: rtl/sad_diff_stage.sv
module sad_diff_stage
  import sad_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [BLK_W-1:0]  cur_blk,
  input  logic [BLK_W-1:0]  ref_blk,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  output logic [BLK_W-1:0]  diff_blk,
  output logic [TAG_W-1:0]  out_tag
);

  logic [BLK_W-1:0] diff_w;
  logic             load_w;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    assign diff_w[p*PIX_W +: PIX_W] = abs_diff(cur_blk[p*PIX_W +: PIX_W],
                                               ref_blk[p*PIX_W +: PIX_W]);
  end

  assign load_w = adv && in_valid;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load_w) begin
      diff_blk <= diff_w;
      out_tag  <= in_tag;
    end
  end

  // R5: a block taken at the input is held by the first stage
  p_take_r5: assert property (@(posedge clk) disable iff (rst)
    (adv && in_valid) |=> out_valid);

endmodule

// File: rtl/sad_row_stage.sv
module sad_row_stage
  import sad_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  in_valid,
  input  logic [BLK_W-1:0]      diff_blk,
  input  logic [TAG_W-1:0]      in_tag,
  output logic                  out_valid,
  output logic [ROWS*ROW_W-1:0] row_sums,
  output logic [TAG_W-1:0]      out_tag
);

  logic [ROWS*ROW_W-1:0] sums_w;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign sums_w[r*ROW_W +: ROW_W] = lane_total(diff_blk[r*WORD_W +: WORD_W]);

    // R2: a row score stays within four full-scale lanes
    p_row_range_r2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (int'(row_sums[r*ROW_W +: ROW_W]) <= ROW_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      row_sums <= sums_w;
      out_tag  <= in_tag;
    end
  end

  // R4: a valid block moves on whenever the pipe advances
  p_flow_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && in_valid) |=> out_valid);

endmodule

// File: rtl/sad_tree_stage.sv
module sad_tree_stage
  import sad_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  adv,
  input  logic                  in_valid,
  input  logic [ROWS*ROW_W-1:0] row_sums,
  input  logic [TAG_W-1:0]      in_tag,
  output logic                  out_valid,
  output logic [TOT_W-1:0]      total,
  output logic [TAG_W-1:0]      out_tag
);

  logic [PAIR_W-1:0] pair_lo_w;
  logic [PAIR_W-1:0] pair_hi_w;
  logic [TOT_W-1:0]  total_w;

  assign pair_lo_w = PAIR_W'(row_sums[0*ROW_W +: ROW_W]) + PAIR_W'(row_sums[1*ROW_W +: ROW_W]);
  assign pair_hi_w = PAIR_W'(row_sums[2*ROW_W +: ROW_W]) + PAIR_W'(row_sums[3*ROW_W +: ROW_W]);
  assign total_w   = TOT_W'(pair_lo_w) + TOT_W'(pair_hi_w);

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (adv) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      total   <= total_w;
      out_tag <= in_tag;
    end
  end

  // R3: the tree total never exceeds sixteen full-scale lanes
  p_total_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(total) <= TOT_MAX));

  // R3: each pair sum of row scores stays within two rows
  p_pair_range_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (int'(pair_lo_w) <= 2*ROW_MAX && int'(pair_hi_w) <= 2*ROW_MAX));

endmodule

// File: rtl/sad4x4_engine.sv
module sad4x4_engine
  import sad_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_cur,
  input  logic [BLK_W-1:0]  in_ref,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TOT_W-1:0]  out_sad,
  output logic [TAG_W-1:0]  out_tag,
  output logic [CNT_W-1:0]  out_cnt
);

  logic                  adv_w;
  logic                  deliver_w;
  logic                  s1_valid, s2_valid;
  logic [BLK_W-1:0]      s1_diff;
  logic [TAG_W-1:0]      s1_tag, s2_tag;
  logic [ROWS*ROW_W-1:0] s2_rows;

  assign adv_w     = !out_valid || out_ready;
  assign in_ready  = adv_w;
  assign deliver_w = out_valid && out_ready;

  sad_diff_stage #(.TAG_W(TAG_W)) u_diff (
    .clk(clk), .rst(rst), .adv(adv_w), .in_valid(in_valid),
    .cur_blk(in_cur), .ref_blk(in_ref), .in_tag(in_tag),
    .out_valid(s1_valid), .diff_blk(s1_diff), .out_tag(s1_tag)
  );

  sad_row_stage #(.TAG_W(TAG_W)) u_row (
    .clk(clk), .rst(rst), .adv(adv_w), .in_valid(s1_valid),
    .diff_blk(s1_diff), .in_tag(s1_tag),
    .out_valid(s2_valid), .row_sums(s2_rows), .out_tag(s2_tag)
  );

  sad_tree_stage #(.TAG_W(TAG_W)) u_tree (
    .clk(clk), .rst(rst), .adv(adv_w), .in_valid(s2_valid),
    .row_sums(s2_rows), .in_tag(s2_tag),
    .out_valid(out_valid), .total(out_sad), .out_tag(out_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) out_cnt <= '0;
    else if (deliver_w) out_cnt <= out_cnt + 1'b1;
  end

  // R6: a result not taken stays put
  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sad) && $stable(out_tag)));

  // R9: one count per delivered result
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    deliver_w |=> (out_cnt == $past(out_cnt) + 1'b1));

  // R9: no count without a delivery
  p_cnt_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !deliver_w |=> $stable(out_cnt));

  // R5: an empty output stage never refuses input
  p_ready_empty_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

endmodule

// File: tb/sad4x4_engine_bench.sv
module sad4x4_engine_bench;
  import sad_pkg::*;

  localparam int CLK_P = 10;
  localparam int TAG_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [BLK_W-1:0] in_cur = '0;
  logic [BLK_W-1:0] in_ref = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [TOT_W-1:0] out_sad;
  logic [TAG_W-1:0] out_tag;
  logic [CNT_W-1:0] out_cnt;

  always #(CLK_P/2) clk = ~clk;

  sad4x4_engine #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_sad4x4_engine (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cur(in_cur), .in_ref(in_ref), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_sad(out_sad),
    .out_tag(out_tag), .out_cnt(out_cnt)
  );

  int total = 0;
  int bad = 0;
  int exp_sad [0:8191];
  int exp_tag [0:8191];
  int acc_cyc [0:8191];
  int wr = 0, rd = 0, cyc = 0, cnt_model = 0, tag_ctr = 0;
  bit sent = 0, hold_pend = 0, lat_mode = 0;
  int h_sad = 0, h_tag = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // independent model: per-row sums of per-pixel distances
  function automatic int model_sad(input logic [BLK_W-1:0] c, input logic [BLK_W-1:0] r);
    int sum = 0;
    for (int row = 0; row < 4; row++) begin
      int rs = 0;
      for (int ln = 0; ln < 4; ln++) begin
        int a = int'(c[(row*32) + (ln*8) +: 8]);
        int b = int'(r[(row*32) + (ln*8) +: 8]);
        rs += (a > b) ? (a - b) : (b - a);
      end
      sum += rs;
    end
    return sum;
  endfunction

  task automatic make_block(input int mode, input int k);
    for (int p = 0; p < 16; p++) begin
      case (mode)
        0: begin
          in_cur[p*8 +: 8] = (k == 1 || k == 3) ? 8'hFF : 8'h00;
          in_ref[p*8 +: 8] = (k == 2 || k == 3) ? 8'hFF : 8'h00;
          if (k == 4) begin
            in_cur[p*8 +: 8] = (p == 9) ? 8'd200 : 8'd0;
            in_ref[p*8 +: 8] = (p == 6) ? 8'd3 : 8'd0;
          end
        end
        1: begin
          in_cur[p*8 +: 8] = 8'((k + 16*p) & 255);
          in_ref[p*8 +: 8] = 8'((255 - k + 5*p) & 255);
        end
        default: begin
          in_cur[p*8 +: 8] = 8'($urandom_range(0, 255));
          in_ref[p*8 +: 8] = 8'($urandom_range(0, 255));
        end
      endcase
    end
  endtask

  task automatic step(input int mode, input int ready_pct, input int valid_pct,
                      inout int remaining, inout int idx);
    @(negedge clk);
    if (sent) begin in_valid = 1'b0; sent = 0; end
    out_ready = ($urandom_range(0, 99) < ready_pct);
    if (!in_valid && remaining > 0 && $urandom_range(0, 99) < valid_pct) begin
      make_block(mode, idx);
      in_tag = TAG_W'(tag_ctr);
      in_valid = 1'b1;
    end
    #1;
    cyc++;
    if (hold_pend) begin
      check(out_valid, "R6 valid held", int'(out_valid), 1);
      check(int'(out_sad) == h_sad, "R6 sad held", int'(out_sad), h_sad);
      check(int'(out_tag) == h_tag, "R6 tag held", int'(out_tag), h_tag);
    end
    check(in_ready == (!out_valid || out_ready), "R5 ready", int'(in_ready),
          int'(!out_valid || out_ready));
    check(int'(out_cnt) == cnt_model, "R9 count", int'(out_cnt), cnt_model);
    hold_pend = out_valid && !out_ready;
    h_sad = int'(out_sad);
    h_tag = int'(out_tag);
    if (out_valid && out_ready) begin
      if (rd == wr) check(0, "R7 unexpected result", int'(out_sad), -1);
      else begin
        check(int'(out_sad) == exp_sad[rd], "R1 R2 R3 total", int'(out_sad), exp_sad[rd]);
        check(int'(out_tag) == exp_tag[rd], "R7 tag", int'(out_tag), exp_tag[rd]);
        if (lat_mode)
          check(cyc - acc_cyc[rd] == 3, "R4 latency", cyc - acc_cyc[rd], 3);
        rd++;
      end
      cnt_model = (cnt_model + 1) % (1 << CNT_W);
    end
    if (in_valid && in_ready) begin
      exp_sad[wr] = model_sad(in_cur, in_ref);
      exp_tag[wr] = int'(in_tag);
      acc_cyc[wr] = cyc;
      wr++;
      remaining--;
      idx++;
      tag_ctr = (tag_ctr + 1) % (1 << TAG_W);
      sent = 1;
    end
  endtask

  task automatic run_phase(input int mode, input int n, input int ready_pct,
                           input int valid_pct, input bit lat);
    int remaining = n;
    int idx = 0;
    lat_mode = lat;
    while (remaining > 0 || rd != wr) step(mode, ready_pct, valid_pct, remaining, idx);
    @(negedge clk);
    if (sent) begin in_valid = 1'b0; sent = 0; end
    hold_pend = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R8 reset valid", int'(out_valid), 0);
    check(out_cnt == '0, "R8 reset count", int'(out_cnt), 0);
    check(in_ready, "R8 reset ready", int'(in_ready), 1);

    run_phase(0, 5, 100, 100, 1);     // corners: 0, 4080, 4080, 0, 203
    run_phase(1, 256, 100, 100, 1);   // 4096-pair sweep, back to back
    run_phase(2, 1500, 60, 70, 0);    // random valid and ready
    run_phase(2, 200, 100, 40, 1);    // bubbles, no stalls
    run_phase(2, 200, 20, 100, 0);    // heavy backpressure
    run_phase(0, 5, 30, 100, 0);      // corners under stalls

    // R8: reset with blocks in flight
    out_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      make_block(2, i);
      in_valid = 1'b1;
    end
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R8 flush valid", int'(out_valid), 0);
    check(out_cnt == '0, "R8 flush count", int'(out_cnt), 0);
    check(in_ready, "R8 flush ready", int'(in_ready), 1);
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!out_valid, "R8 no stale result", int'(out_valid), 0);
    wr = 0; rd = 0; cnt_model = 0; hold_pend = 0; sent = 0;
    run_phase(0, 5, 100, 100, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule